// File: doc/BRIEF.md
# Retro CPU Bus Host Controller

This block is the single companion controller for an external 8-bit CPU of the two-phase-clock kind. It divides a fast system clock into the CPU clock. It holds the CPU in reset for a fixed count of CPU cycles and then lets it run. It drives the interrupt lines and controls the chip-enable, output-enable and write-enable of an external SRAM. A relocatable 4 KiB address window is served from an internal byte store, and the SRAM is kept off while the window is in use. Address ranges can be write-protected, so a CPU write there never reaches memory and those ranges act as ROM.

Every CPU bus cycle is logged into a circular trace store that can be read back later. Before the CPU is started, a host write port loads the configuration registers and preloads the window store, for example with the reset vector and a first program. Once the run bit is set, the port is locked.

Top module: `retro_bus_host`

## Requirements
- R1: The CPU clock period is the PERIOD register value in system ticks, with values below 8 acting as 8. The clock is low for floor(P/2) ticks, starting at the cycle start, and high for the remaining ticks (phase 2).
- R2: Before the run bit is set, `cpu_phi2` is low and `cpu_res_n` is low. After start, `cpu_res_n` stays low for exactly the first two CPU cycles and is high from the third cycle onwards.
- R3: An access whose upper address bits [15:12] equal the window base register bits [15:12] is a window hit (reset base 0xF000). During a hit cycle `sram_ce_n`, `sram_oe_n` and `sram_we_n` all stay high.
- R4: On a window read (`cpu_rw`=1), `cpu_d_oe` is high in phase 2 and `cpu_d_out` carries the store byte at address bits [11:0].
- R5: On a window write, the byte on `cpu_d_in` is captured HOLD+1 ticks before the end of the cycle, and a later read of that address returns it.
- R6: An access outside the window drives `sram_ce_n` low in phase 2. A read also drives `sram_oe_n` low, and a write drives `sram_we_n` low instead; `cpu_d_oe` stays low in both cases.
- R7: A write into an enabled protected range (lo <= addr <= hi, inclusive, enabled when lo <= hi) keeps `sram_we_n` high and leaves the window store unchanged.
- R8: Each CPU cycle writes one trace entry {hit[25], rw[24], addr[23:8], data[7:0]} at the write pointer, which then advances. The data field holds the driven byte for a window read and otherwise the `cpu_d_in` byte at the capture tick.
- R9: The 8-bit trace pointer wraps from 255 to 0, and `trace_wrapped` is set from that wrap onwards.
- R10: `cpu_irq_n` and `cpu_nmi_n` are the inverted levels of `irq_req` and `nmi_req` taken at the first tick of each CPU cycle.
- R11: Host writes take effect only before start. With `host_mem`=0, `host_addr[3:0]` selects a register: 0 run (bit 0), 1 PERIOD (bits 7:0), 2 window base, 3/4 range-0 lo/hi, 5/6 range-1 lo/hi. With `host_mem`=1, `host_wdata[7:0]` is written to the window store if `host_addr` lies in the window.
- R12: `cpu_d_oe` is never high while `sram_oe_n` is low or during a CPU write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_we | input | 1 | Host write strobe |
| host_mem | input | 1 | 1 selects window store, 0 selects registers |
| host_addr | input | 16 | Register index or store address |
| host_wdata | input | 16 | Host write data |
| irq_req | input | 1 | Interrupt request level |
| nmi_req | input | 1 | Non-maskable interrupt request level |
| cpu_addr | input | 16 | CPU address bus |
| cpu_rw | input | 1 | CPU read (1) / write (0) |
| cpu_d_in | input | 8 | CPU data bus as seen by the controller |
| cpu_d_out | output | 8 | Byte driven onto the CPU data bus |
| cpu_d_oe | output | 1 | Data bus drive enable |
| cpu_phi2 | output | 1 | CPU clock |
| cpu_res_n | output | 1 | CPU reset, active low |
| cpu_irq_n | output | 1 | CPU interrupt, active low |
| cpu_nmi_n | output | 1 | CPU non-maskable interrupt, active low |
| sram_ce_n | output | 1 | SRAM chip enable, active low |
| sram_oe_n | output | 1 | SRAM output enable, active low |
| sram_we_n | output | 1 | SRAM write enable, active low |
| trace_raddr | input | 8 | Trace read index |
| trace_rdata | output | 26 | Trace entry at the read index |
| trace_wptr | output | 8 | Next trace slot to be written |
| trace_wrapped | output | 1 | Trace pointer has wrapped at least once |

## Verification
The bench measures whole clock periods and phase-2 widths for an even period, an odd period and a period below the floor. An off-by-one divider would show up in those lengths, and so would a missing clamp. It counts the CPU cycles that pass with reset low: a stretcher that released after one cycle or after three would be caught there. The bench also writes at both ends of a protected range, where a range compare with a wrong edge would let a ROM byte change. Window reads during the reset vector fetch, a relocated window and the trace-pointer wrap at 256 entries are covered, as are host writes made after start, which would alter the running period if the lock were missing.

// File: rtl/cbh_pkg.sv
// Shared constants and types for the retro CPU bus host.
// Assumes a 16-bit CPU address and an 8-bit data bus.
package cbh_pkg;
    localparam int ADDR_W  = 16;
    localparam int DATA_W  = 8;
    localparam int TRACE_W = 2 + ADDR_W + DATA_W;

    // Host register indices (host_addr[3:0])
    localparam int REG_GO      = 0;
    localparam int REG_PERIOD  = 1;
    localparam int REG_WINBASE = 2;
    localparam int REG_PROT0   = 3;   // range k: lo at 3+2k, hi at 4+2k

    typedef struct packed {
        logic              hit;
        logic              rw;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } trace_ent_t;
endpackage

// File: rtl/cbh_phase.sv
// CPU clock divider and reset stretcher.
// Counts system ticks per CPU cycle and emits one-tick strobes at the
// cycle start, the address sample point, the data capture point and the
// cycle end. Assumes period is only changed while run is low.
module cbh_phase #(
    parameter int TICK_W  = 8,
    parameter int HOLD    = 2,
    parameter int RST_CYC = 2,
    parameter int MIN_PER = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [TICK_W-1:0] period,
    output logic              phi2,
    output logic              at_start,
    output logic              at_samp,
    output logic              at_latch,
    output logic              at_end,
    output logic              res_n
);
    localparam int RC_W = $clog2(RST_CYC + 1);

    logic [TICK_W-1:0] per_eff;
    logic [TICK_W-1:0] half;
    logic [TICK_W-1:0] tick_q;
    logic [RC_W-1:0]   rcnt_q;

    assign per_eff = (period < TICK_W'(MIN_PER)) ? TICK_W'(MIN_PER) : period;
    assign half    = per_eff >> 1;

    assign phi2     = run && (tick_q >= half);
    assign at_start = run && (tick_q == '0);
    assign at_samp  = run && (tick_q == half - TICK_W'(1));
    assign at_latch = run && (tick_q == per_eff - TICK_W'(HOLD + 1));
    assign at_end   = run && (tick_q == per_eff - TICK_W'(1));
    assign res_n    = run && (rcnt_q == RC_W'(RST_CYC));

    // Tick counter within one CPU cycle
    always_ff @(posedge clk) begin
        if (!rst_n)
            tick_q <= '0;
        else if (!run || at_end)
            tick_q <= '0;
        else
            tick_q <= tick_q + TICK_W'(1);
    end

    // Counts completed CPU cycles up to the reset length
    always_ff @(posedge clk) begin
        if (!rst_n)
            rcnt_q <= '0;
        else if (at_end && rcnt_q != RC_W'(RST_CYC))
            rcnt_q <= rcnt_q + RC_W'(1);
    end
endmodule

// File: rtl/cbh_decode.sv
// Window hit and write-protect decode for one sampled address.
// A range is active only when its lower bound does not exceed its upper.
module cbh_decode #(
    parameter int ADDR_W = 16,
    parameter int WIN_AW = 12,
    parameter int NPROT  = 2
) (
    input  logic [ADDR_W-1:0]             addr,
    input  logic [ADDR_W-WIN_AW-1:0]      win_hi,
    input  logic [NPROT-1:0][ADDR_W-1:0]  prot_lo,
    input  logic [NPROT-1:0][ADDR_W-1:0]  prot_hi,
    output logic                          hit,
    output logic                          prot
);
    logic [NPROT-1:0] in_rng;

    assign hit = (addr[ADDR_W-1:WIN_AW] == win_hi);

    for (genvar k = 0; k < NPROT; k++) begin : g_rng
        // One inclusive range compare per protected region
        assign in_rng[k] = (prot_lo[k] <= prot_hi[k]) &&
                           (addr >= prot_lo[k]) && (addr <= prot_hi[k]);
    end

    assign prot = |in_rng;
endmodule

// File: rtl/cbh_winmem.sv
// Internal byte store behind the address window.
// Host and CPU writes never overlap in time (host only before start);
// the host port still takes priority. Read is combinational.
module cbh_winmem #(
    parameter int AW = 12,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          host_we,
    input  logic [AW-1:0] host_idx,
    input  logic [DW-1:0] host_data,
    input  logic          cpu_we,
    input  logic [AW-1:0] cpu_idx,
    input  logic [DW-1:0] cpu_data,
    input  logic [AW-1:0] rd_idx,
    output logic [DW-1:0] rd_data
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    assign rd_data = mem[rd_idx];

    // Byte write from host preload or CPU window write
    always_ff @(posedge clk) begin
        if (host_we)
            mem[host_idx] <= host_data;
        else if (cpu_we)
            mem[cpu_idx] <= cpu_data;
    end
endmodule

// File: rtl/cbh_trace.sv
// Circular bus-cycle trace store with wrap pointer and wrapped flag.
// One entry per write strobe; read is combinational by index.
module cbh_trace #(
    parameter int PTR_W = 8,
    parameter int W     = 26
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [W-1:0]     wr_data,
    input  logic [PTR_W-1:0] rd_addr,
    output logic [W-1:0]     rd_data,
    output logic [PTR_W-1:0] wptr,
    output logic             wrapped
);
    localparam int DEPTH = 1 << PTR_W;

    logic [W-1:0] mem [DEPTH];

    assign rd_data = mem[rd_addr];

    // Stores the entry at the current slot
    always_ff @(posedge clk) begin
        if (wr_en)
            mem[wptr] <= wr_data;
    end

    // Advances the pointer and records the first wrap
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr    <= '0;
            wrapped <= 1'b0;
        end else if (wr_en) begin
            wptr <= wptr + PTR_W'(1);
            if (wptr == {PTR_W{1'b1}})
                wrapped <= 1'b1;
        end
    end
endmodule

// File: rtl/retro_bus_host.sv
// Companion controller for an external two-phase 8-bit CPU.
// Generates the CPU clock and reset, drives the interrupt lines, gates an
// external SRAM, serves a relocatable window from an internal store,
// blocks writes to protected ranges and traces every bus cycle.
// Assumes the CPU address and R/W are stable from the middle of phase 1
// to the end of phase 2, and configuration is written before start.
module retro_bus_host
    import cbh_pkg::*;
#(
    parameter int TICK_W     = 8,
    parameter int PERIOD_RST = 88,
    parameter int HOLD       = 2,
    parameter int RST_CYC    = 2,
    parameter int WIN_AW     = 12,
    parameter int NPROT      = 2,
    parameter int TRACE_AW   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                host_we,
    input  logic                host_mem,
    input  logic [ADDR_W-1:0]   host_addr,
    input  logic [ADDR_W-1:0]   host_wdata,
    input  logic                irq_req,
    input  logic                nmi_req,
    input  logic [ADDR_W-1:0]   cpu_addr,
    input  logic                cpu_rw,
    input  logic [DATA_W-1:0]   cpu_d_in,
    output logic [DATA_W-1:0]   cpu_d_out,
    output logic                cpu_d_oe,
    output logic                cpu_phi2,
    output logic                cpu_res_n,
    output logic                cpu_irq_n,
    output logic                cpu_nmi_n,
    output logic                sram_ce_n,
    output logic                sram_oe_n,
    output logic                sram_we_n,
    input  logic [TRACE_AW-1:0] trace_raddr,
    output logic [TRACE_W-1:0]  trace_rdata,
    output logic [TRACE_AW-1:0] trace_wptr,
    output logic                trace_wrapped
);
    localparam int HI_W = ADDR_W - WIN_AW;

    // Configuration state
    logic                         run_q;
    logic [TICK_W-1:0]            period_q;
    logic [HI_W-1:0]              win_hi_q;
    logic [NPROT-1:0][ADDR_W-1:0] prot_lo_q;
    logic [NPROT-1:0][ADDR_W-1:0] prot_hi_q;

    // Per-cycle bus state
    logic [ADDR_W-1:0] a_q;
    logic              rw_q;
    logic [DATA_W-1:0] d_lat_q;
    logic              irq_q, nmi_q;

    logic phi2, at_start, at_samp, at_latch, at_end, res_n;
    logic hit, prot;
    logic [DATA_W-1:0] win_rd;
    logic host_cfg_we, host_mem_we, host_in_win;
    logic cpu_win_we;
    trace_ent_t ent;

    assign host_in_win = (host_addr[ADDR_W-1:WIN_AW] == win_hi_q);
    assign host_cfg_we = host_we && !host_mem && !run_q;
    assign host_mem_we = host_we && host_mem && !run_q && host_in_win;

    // Host register writes, locked once the CPU is started
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q     <= 1'b0;
            period_q  <= TICK_W'(PERIOD_RST);
            win_hi_q  <= '1;
            prot_lo_q <= '1;
            prot_hi_q <= '0;
        end else if (host_cfg_we) begin
            if (host_addr[3:0] == 4'(REG_GO))
                run_q <= host_wdata[0];
            if (host_addr[3:0] == 4'(REG_PERIOD))
                period_q <= host_wdata[TICK_W-1:0];
            if (host_addr[3:0] == 4'(REG_WINBASE))
                win_hi_q <= host_wdata[ADDR_W-1:WIN_AW];
            for (int k = 0; k < NPROT; k++) begin
                if (host_addr[3:0] == 4'(REG_PROT0 + 2 * k))
                    prot_lo_q[k] <= host_wdata;
                if (host_addr[3:0] == 4'(REG_PROT0 + 2 * k + 1))
                    prot_hi_q[k] <= host_wdata;
            end
        end
    end

    cbh_phase #(
        .TICK_W (TICK_W),
        .HOLD   (HOLD),
        .RST_CYC(RST_CYC)
    ) u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run_q),
        .period  (period_q),
        .phi2    (phi2),
        .at_start(at_start),
        .at_samp (at_samp),
        .at_latch(at_latch),
        .at_end  (at_end),
        .res_n   (res_n)
    );

    // Address and direction sampled at the end of phase 1
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q  <= '0;
            rw_q <= 1'b1;
        end else if (at_samp) begin
            a_q  <= cpu_addr;
            rw_q <= cpu_rw;
        end
    end

    // Interrupt levels taken at the first tick of each cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
            nmi_q <= 1'b0;
        end else if (at_start) begin
            irq_q <= irq_req;
            nmi_q <= nmi_req;
        end
    end

    cbh_decode #(
        .ADDR_W(ADDR_W),
        .WIN_AW(WIN_AW),
        .NPROT (NPROT)
    ) u_dec (
        .addr   (a_q),
        .win_hi (win_hi_q),
        .prot_lo(prot_lo_q),
        .prot_hi(prot_hi_q),
        .hit    (hit),
        .prot   (prot)
    );

    assign cpu_win_we = at_latch && hit && !rw_q && !prot;

    cbh_winmem #(
        .AW(WIN_AW),
        .DW(DATA_W)
    ) u_win (
        .clk      (clk),
        .host_we  (host_mem_we),
        .host_idx (host_addr[WIN_AW-1:0]),
        .host_data(host_wdata[DATA_W-1:0]),
        .cpu_we   (cpu_win_we),
        .cpu_idx  (a_q[WIN_AW-1:0]),
        .cpu_data (cpu_d_in),
        .rd_idx   (a_q[WIN_AW-1:0]),
        .rd_data  (win_rd)
    );

    // Bus byte held for the trace, taken at the capture tick
    always_ff @(posedge clk) begin
        if (!rst_n)
            d_lat_q <= '0;
        else if (at_latch)
            d_lat_q <= (hit && rw_q) ? win_rd : cpu_d_in;
    end

    assign ent.hit  = hit;
    assign ent.rw   = rw_q;
    assign ent.addr = a_q;
    assign ent.data = d_lat_q;

    cbh_trace #(
        .PTR_W(TRACE_AW),
        .W    (TRACE_W)
    ) u_trace (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (at_end),
        .wr_data(ent),
        .rd_addr(trace_raddr),
        .rd_data(trace_rdata),
        .wptr   (trace_wptr),
        .wrapped(trace_wrapped)
    );

    assign cpu_phi2  = phi2;
    assign cpu_res_n = res_n;
    assign cpu_irq_n = !irq_q;
    assign cpu_nmi_n = !nmi_q;
    assign cpu_d_out = win_rd;
    assign cpu_d_oe  = phi2 && hit && rw_q;
    assign sram_ce_n = !(phi2 && !hit);
    assign sram_oe_n = !(phi2 && !hit && rw_q);
    assign sram_we_n = !(phi2 && !hit && !rw_q && !prot);
endmodule

// File: rtl/cbh_checker.sv
// Protocol checks on the bus host outputs; attached by bind below.
module cbh_checker #(
    parameter int PTR_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run,
    input logic             cpu_phi2,
    input logic             cpu_res_n,
    input logic             cpu_rw,
    input logic             cpu_d_oe,
    input logic             sram_ce_n,
    input logic             sram_oe_n,
    input logic             sram_we_n,
    input logic [PTR_W-1:0] trace_wptr
);
    AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_d_oe |-> sram_oe_n);                                     // R12
    AST_NO_DRIVE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_d_oe |-> cpu_rw);                                        // R12
    AST_HIT_SRAM_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_d_oe |-> (sram_ce_n && sram_we_n));                      // R3
    AST_IDLE_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (!cpu_res_n && !cpu_phi2));                         // R2
    AST_RESET_STAYS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_res_n |=> cpu_res_n);                                    // R2
    AST_RESET_AT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_res_n) |-> !cpu_phi2);                             // R2
    AST_WE_ONLY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> (cpu_phi2 && !cpu_rw && !sram_ce_n));         // R6
    AST_WPTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (trace_wptr != $past(trace_wptr)) |->
        (trace_wptr == $past(trace_wptr) + PTR_W'(1)));              // R9
endmodule

bind retro_bus_host cbh_checker #(.PTR_W(TRACE_AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run_q),
    .cpu_phi2  (cpu_phi2),
    .cpu_res_n (cpu_res_n),
    .cpu_rw    (cpu_rw),
    .cpu_d_oe  (cpu_d_oe),
    .sram_ce_n (sram_ce_n),
    .sram_oe_n (sram_oe_n),
    .sram_we_n (sram_we_n),
    .trace_wptr(trace_wptr)
);

// File: tb/sim_retro_bus_host.sv
// Directed bench for the retro CPU bus host; the CPU and SRAM are stimulus.
module sim_retro_bus_host;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0, host_mem = 1'b0;
    logic [15:0] host_addr = '0, host_wdata = '0;
    logic        irq_req = 1'b0, nmi_req = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic        cpu_rw = 1'b1;
    logic [7:0]  cpu_d_in = '0;
    logic [7:0]  cpu_d_out;
    logic        cpu_d_oe, cpu_phi2, cpu_res_n, cpu_irq_n, cpu_nmi_n;
    logic        sram_ce_n, sram_oe_n, sram_we_n;
    logic [7:0]  trace_raddr = '0;
    logic [25:0] trace_rdata;
    logic [7:0]  trace_wptr;
    logic        trace_wrapped;

    int n_run = 0, n_fail = 0;
    bit done = 0;

    // Values seen in phase 2 of the last bus cycle
    logic s_ce, s_oe, s_we, s_doe, s_res, s_irq, s_nmi;
    logic [7:0] s_dout;
    int last_ticks, last_hi;

    always #4 clk = ~clk;

    retro_bus_host u0 (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_mem(host_mem),
        .host_addr(host_addr), .host_wdata(host_wdata),
        .irq_req(irq_req), .nmi_req(nmi_req),
        .cpu_addr(cpu_addr), .cpu_rw(cpu_rw), .cpu_d_in(cpu_d_in),
        .cpu_d_out(cpu_d_out), .cpu_d_oe(cpu_d_oe), .cpu_phi2(cpu_phi2),
        .cpu_res_n(cpu_res_n), .cpu_irq_n(cpu_irq_n), .cpu_nmi_n(cpu_nmi_n),
        .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n),
        .trace_raddr(trace_raddr), .trace_rdata(trace_rdata),
        .trace_wptr(trace_wptr), .trace_wrapped(trace_wrapped)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        cpu_addr = '0; cpu_rw = 1'b1; cpu_d_in = '0;
        irq_req = 1'b0; nmi_req = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic host_write(input logic mem, input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        host_we = 1'b1; host_mem = mem; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0; host_mem = 1'b0;
    endtask

    // Called at tick 0 of a cycle; returns at tick 0 of the next one
    task automatic bus_cycle(input logic [15:0] a, input logic rw, input logic [7:0] d);
        cpu_addr = a; cpu_rw = rw; cpu_d_in = d;
        last_ticks = 0; last_hi = 0;
        do begin @(negedge clk); last_ticks++; end while (!cpu_phi2);
        s_ce = sram_ce_n; s_oe = sram_oe_n; s_we = sram_we_n;
        s_doe = cpu_d_oe; s_dout = cpu_d_out; s_res = cpu_res_n;
        s_irq = cpu_irq_n; s_nmi = cpu_nmi_n;
        do begin @(negedge clk); last_ticks++; last_hi++; end while (cpu_phi2);
    endtask

    task automatic resync();
        do @(negedge clk); while (!cpu_phi2);
        do @(negedge clk); while (cpu_phi2);
    endtask

    task automatic start();
        host_write(1'b0, 16'd0, 16'd1);
    endtask

    task automatic reset_cycles();
        bus_cycle(16'h0000, 1'b1, 8'h00);
        bus_cycle(16'h0000, 1'b1, 8'h00);
    endtask

    task automatic chk_trace(input int idx, input logic [25:0] exp);
        @(negedge clk);
        trace_raddr = 8'(idx);
        #1;
        check("R8", "trace entry", {6'd0, trace_rdata}, {6'd0, exp});
    endtask

    // R1 and R2: idle state, reset stretch, even period
    task automatic t_reset();
        do_reset();
        repeat (4) @(negedge clk);
        check("R2", "phi2 idle", {31'd0, cpu_phi2}, 32'd0);
        check("R2", "res_n idle", {31'd0, cpu_res_n}, 32'd0);
        host_write(1'b0, 16'd1, 16'd16);
        start();
        bus_cycle(16'h0000, 1'b1, 8'h00);
        check("R2", "res_n cycle 0", {31'd0, s_res}, 32'd0);
        check("R1", "period 16", last_ticks, 32'd16);
        check("R1", "phase2 16", last_hi, 32'd8);
        bus_cycle(16'h0000, 1'b1, 8'h00);
        check("R2", "res_n cycle 1", {31'd0, s_res}, 32'd0);
        bus_cycle(16'h0000, 1'b1, 8'h00);
        check("R2", "res_n cycle 2", {31'd0, s_res}, 32'd1);
    endtask

    // R1: odd period and clamp below the floor
    task automatic t_period();
        do_reset();
        host_write(1'b0, 16'd1, 16'd21);
        start();
        bus_cycle(16'h0000, 1'b1, 8'h00);
        check("R1", "period 21", last_ticks, 32'd21);
        check("R1", "phase2 21", last_hi, 32'd11);
        do_reset();
        host_write(1'b0, 16'd1, 16'd5);
        start();
        bus_cycle(16'h0000, 1'b1, 8'h00);
        check("R1", "period clamp", last_ticks, 32'd8);
        check("R1", "phase2 clamp", last_hi, 32'd4);
    endtask

    // R3..R6, R8, R12: vector fetch, window write, SRAM cycles, trace
    task automatic t_window();
        do_reset();
        host_write(1'b0, 16'd1, 16'd16);
        host_write(1'b1, 16'hFFFC, 16'h0000);
        host_write(1'b1, 16'hFFFD, 16'h00F0);
        start();
        reset_cycles();
        bus_cycle(16'hFFFC, 1'b1, 8'h00);
        check("R4", "vector lo oe", {31'd0, s_doe}, 32'd1);
        check("R4", "vector lo", {24'd0, s_dout}, 32'h00);
        check("R3", "hit ce_n", {31'd0, s_ce}, 32'd1);
        check("R3", "hit oe_n", {31'd0, s_oe}, 32'd1);
        bus_cycle(16'hFFFD, 1'b1, 8'h00);
        check("R4", "vector hi", {24'd0, s_dout}, 32'hF0);
        bus_cycle(16'hF010, 1'b0, 8'h5A);
        check("R3", "hit we_n", {31'd0, s_we}, 32'd1);
        check("R12", "no drive on write", {31'd0, s_doe}, 32'd0);
        bus_cycle(16'hF010, 1'b1, 8'h00);
        check("R5", "window readback", {24'd0, s_dout}, 32'h5A);
        bus_cycle(16'h0080, 1'b1, 8'h33);
        check("R6", "read ce_n", {31'd0, s_ce}, 32'd0);
        check("R6", "read oe_n", {31'd0, s_oe}, 32'd0);
        check("R6", "read we_n", {31'd0, s_we}, 32'd1);
        check("R12", "no drive with sram oe", {31'd0, s_doe}, 32'd0);
        bus_cycle(16'h80F9, 1'b0, 8'h22);
        check("R6", "write we_n", {31'd0, s_we}, 32'd0);
        check("R6", "write oe_n", {31'd0, s_oe}, 32'd1);
        bus_cycle(16'h0080, 1'b1, 8'h33);
        check("R8", "trace pointer", {24'd0, trace_wptr}, 32'd9);
        chk_trace(2, {1'b1, 1'b1, 16'hFFFC, 8'h00});
        chk_trace(4, {1'b1, 1'b0, 16'hF010, 8'h5A});
        chk_trace(6, {1'b0, 1'b1, 16'h0080, 8'h33});
        chk_trace(7, {1'b0, 1'b0, 16'h80F9, 8'h22});
    endtask

    // R3 relocation and R7 protected ranges with boundaries
    task automatic t_protect();
        do_reset();
        host_write(1'b0, 16'd1, 16'd16);
        host_write(1'b0, 16'd2, 16'hA000);
        host_write(1'b0, 16'd3, 16'h2000);
        host_write(1'b0, 16'd4, 16'h2FFF);
        host_write(1'b0, 16'd5, 16'hA800);
        host_write(1'b0, 16'd6, 16'hA8FF);
        host_write(1'b1, 16'hA805, 16'h0077);
        host_write(1'b1, 16'hA123, 16'h0042);
        start();
        reset_cycles();
        bus_cycle(16'hA123, 1'b1, 8'h00);
        check("R3", "relocated hit", {23'd0, s_doe, s_dout}, {23'd0, 1'b1, 8'h42});
        bus_cycle(16'hF000, 1'b1, 8'h00);
        check("R3", "old base misses", {31'd0, s_ce}, 32'd0);
        bus_cycle(16'h2100, 1'b0, 8'h01);
        check("R7", "protected we_n", {31'd0, s_we}, 32'd1);
        bus_cycle(16'h2FFF, 1'b0, 8'h01);
        check("R7", "upper bound we_n", {31'd0, s_we}, 32'd1);
        bus_cycle(16'h2000, 1'b0, 8'h01);
        check("R7", "lower bound we_n", {31'd0, s_we}, 32'd1);
        bus_cycle(16'h1FFF, 1'b0, 8'h01);
        check("R7", "below range we_n", {31'd0, s_we}, 32'd0);
        bus_cycle(16'h3000, 1'b0, 8'h01);
        check("R7", "above range we_n", {31'd0, s_we}, 32'd0);
        bus_cycle(16'hA805, 1'b0, 8'h11);
        bus_cycle(16'hA805, 1'b1, 8'h00);
        check("R7", "window ROM kept", {24'd0, s_dout}, 32'h77);
    endtask

    // R10: interrupt lines follow requests per cycle
    task automatic t_irq();
        do_reset();
        host_write(1'b0, 16'd1, 16'd16);
        start();
        reset_cycles();
        irq_req = 1'b1; nmi_req = 1'b0;
        bus_cycle(16'h0000, 1'b1, 8'h00);
        check("R10", "irq asserted", {30'd0, s_irq, s_nmi}, 32'b01);
        irq_req = 1'b0; nmi_req = 1'b1;
        bus_cycle(16'h0000, 1'b1, 8'h00);
        check("R10", "nmi asserted", {30'd0, s_irq, s_nmi}, 32'b10);
        nmi_req = 1'b0;
        bus_cycle(16'h0000, 1'b1, 8'h00);
        check("R10", "both released", {30'd0, s_irq, s_nmi}, 32'b11);
    endtask

    // R11: host writes after start are ignored
    task automatic t_lock();
        do_reset();
        host_write(1'b0, 16'd1, 16'd16);
        host_write(1'b1, 16'hF020, 16'h0044);
        start();
        reset_cycles();
        host_write(1'b0, 16'd1, 16'd40);
        host_write(1'b1, 16'hF020, 16'h0099);
        resync();
        bus_cycle(16'hF020, 1'b1, 8'h00);
        check("R11", "period locked", last_ticks, 32'd16);
        check("R11", "store locked", {24'd0, s_dout}, 32'h44);
    endtask

    // R9: trace pointer wrap
    task automatic t_wrap();
        do_reset();
        host_write(1'b0, 16'd1, 16'd8);
        start();
        for (int i = 0; i < 255; i++) bus_cycle(16'h0010, 1'b1, 8'h00);
        check("R9", "pointer before wrap", {24'd0, trace_wptr}, 32'd255);
        check("R9", "flag before wrap", {31'd0, trace_wrapped}, 32'd0);
        bus_cycle(16'h0010, 1'b1, 8'h00);
        check("R9", "pointer wrapped", {24'd0, trace_wptr}, 32'd0);
        check("R9", "flag set", {31'd0, trace_wrapped}, 32'd1);
        for (int i = 0; i < 4; i++) bus_cycle(16'h0010, 1'b1, 8'h00);
        check("R9", "pointer after wrap", {24'd0, trace_wptr}, 32'd4);
        check("R9", "flag held", {31'd0, trace_wrapped}, 32'd1);
    endtask

    initial begin
        t_reset();
        t_period();
        t_window();
        t_protect();
        t_irq();
        t_lock();
        t_wrap();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog (all requirements): actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule